// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit keeps the sticky event flags of a serial bus controller, together with a per-flag interrupt enable mask and two DMA enable bits. The transfer engine raises flags with single-cycle set pulses. The unit combines the flags and the mask into one level interrupt. It also drives one DMA request line for the receive direction and one for the transmit direction.

Software acknowledges events in one of two ways, chosen by the `NEW_REV` parameter. In the newer style, software writes ones to clear selected flags. In the older style, software reads a vector: the unit returns a code naming the lowest pending enabled flag and clears that flag. A bus-busy input is merged into the status readback but is never stored.

Unit structure: a flag store (`irqv_flags`), a lowest-pending finder (`irqv_prio`), the mask and DMA configuration registers (`irqv_cfg`), and the top level that connects them. The unit has no state machine. Its only sequencing is the per-flag rule: a set pulse forces the flag to 1, otherwise a clear forces it to 0, otherwise the flag holds.

Top module: `irqv_top`

## Requirements
- R1: `irq` is 1 exactly when some bit of the stored status ANDed with the enable mask is 1.
- R2: Status bit 3 is receive-ready and bit 4 is transmit-ready. DMA enable bit 15 is receive and bit 7 is transmit. `dreq_rx` follows bit 3 only while bit 15 is set, and `dreq_tx` follows bit 4 only while bit 7 is set.
- R3: Older revision only: `vec_code` is the index plus 1 of the lowest bit of status AND mask, or 0 when that AND is zero. A `vec_rd` strobe clears that one flag at the next edge. In the newer revision `vec_code` is 0 and `vec_rd` has no effect.
- R4: Newer revision only: a status write clears the bits set in both the written data and 0x0027 (bits 0, 1, 2 and 5). Bits 3 and 4 cannot be cleared by this write. In the older revision a status write has no effect.
- R5: An enable write keeps data bits 5:0 in the newer revision and bits 4:0 in the older revision. All higher enable bits read 0.
- R6: A DMA write keeps only data bits 15 and 7. Data bit 15 clears enable bit 3, and data bit 7 clears enable bit 4, in the same edge.
- R7: `stat_rd` bit 12 equals `busy_in` in the same cycle. A set pulse on bit 12 is not stored.
- R8: When a set pulse and a clear (status write or vector read) hit the same bit in the same cycle, the bit ends up set.
- R9: After reset, status, mask and DMA bits are all zero, and `irq`, `dreq_rx` and `dreq_tx` are 0.
- R10: A set pulse on any stored bit makes that status bit 1 from the next edge, and the bit stays 1 until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_pulse | input | 16 | Per-flag set strobes from the transfer engine |
| busy_in | input | 1 | Bus-busy level, shown at status bit 12 |
| stat_clr_we | input | 1 | Status write-one-to-clear strobe |
| stat_clr_data | input | 16 | Data for the status write |
| en_we | input | 1 | Enable mask write strobe |
| en_data | input | 16 | Data for the enable mask write |
| dma_we | input | 1 | DMA configuration write strobe |
| dma_data | input | 16 | Data for the DMA configuration write |
| vec_rd | input | 1 | Vector read strobe, clears the reported flag |
| vec_code | output | 5 | Lowest pending enabled flag index plus 1, or 0 |
| stat_rd | output | 16 | Status readback including busy |
| en_rd | output | 16 | Enable mask readback |
| dma_rd | output | 16 | DMA configuration readback |
| irq | output | 1 | Level interrupt |
| dreq_rx | output | 1 | Receive DMA request |
| dreq_tx | output | 1 | Transmit DMA request |

## Verification
All outputs are combinational views of registered state. A flag that was wrongly set or lost therefore shows at `stat_rd`, `irq` or `vec_code` in the same cycle that the bad edge takes effect. A stale mask shows as an interrupt that masking should have suppressed. A vector read that clears the wrong bit shows one cycle later as the wrong next code. The bench checks every result one full edge after the stimulus, in both revisions.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int STAT_W     = 16;
    localparam int CODE_W     = $clog2(STAT_W + 1);
    localparam int BIT_RX_RDY = 3;
    localparam int BIT_TX_RDY = 4;
    localparam int BIT_BUSY   = 12;
    localparam int DMA_RX_BIT = 15;
    localparam int DMA_TX_BIT = 7;
    localparam logic [STAT_W-1:0] SW_CLR_MASK = 16'h0027;
    localparam logic [STAT_W-1:0] STORE_MASK  = ~(16'h1 << BIT_BUSY);
endpackage

// File: rtl/irqv_flags.sv
module irqv_flags
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    output logic [STAT_W-1:0] flag_q
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        if (STORE_MASK[i]) begin : g_keep
            always_ff @(posedge clk) begin
                if (!rst_n)          flag_q[i] <= 1'b0;
                else if (set_vec[i]) flag_q[i] <= 1'b1;
                else if (clr_vec[i]) flag_q[i] <= 1'b0;
            end
        end else begin : g_none
            assign flag_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
(
    input  logic [STAT_W-1:0] pend,
    output logic [STAT_W-1:0] pick_onehot,
    output logic [CODE_W-1:0] pick_code
);
    always_comb begin
        pick_onehot = '0;
        pick_code   = '0;
        for (int i = STAT_W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick_onehot = '0;
                pick_onehot[i] = 1'b1;
                pick_code   = CODE_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irqv_cfg.sv
module irqv_cfg
    import irqv_pkg::*;
#(
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic [STAT_W-1:0] en_data,
    input  logic              dma_we,
    input  logic [STAT_W-1:0] dma_data,
    output logic [STAT_W-1:0] mask_ext,
    output logic              dma_rx_en,
    output logic              dma_tx_en
);
    logic [MASK_W-1:0] mask_q, mask_d;

    always_comb begin
        mask_d = mask_q;
        if (en_we) mask_d = en_data[MASK_W-1:0];
        if (dma_we && dma_data[DMA_RX_BIT]) mask_d[BIT_RX_RDY] = 1'b0;
        if (dma_we && dma_data[DMA_TX_BIT]) mask_d[BIT_TX_RDY] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            dma_rx_en <= 1'b0;
            dma_tx_en <= 1'b0;
        end else begin
            mask_q <= mask_d;
            if (dma_we) begin
                dma_rx_en <= dma_data[DMA_RX_BIT];
                dma_tx_en <= dma_data[DMA_TX_BIT];
            end
        end
    end

    assign mask_ext = STAT_W'(mask_q);
endmodule

// File: rtl/irqv_top.sv
module irqv_top
    import irqv_pkg::*;
#(
    parameter int NEW_REV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       set_pulse,
    input  logic              busy_in,
    input  logic              stat_clr_we,
    input  logic [15:0]       stat_clr_data,
    input  logic              en_we,
    input  logic [15:0]       en_data,
    input  logic              dma_we,
    input  logic [15:0]       dma_data,
    input  logic              vec_rd,
    output logic [4:0]        vec_code,
    output logic [15:0]       stat_rd,
    output logic [15:0]       en_rd,
    output logic [15:0]       dma_rd,
    output logic              irq,
    output logic              dreq_rx,
    output logic              dreq_tx
);
    localparam int MASK_W = (NEW_REV != 0) ? 6 : 5;

    logic [STAT_W-1:0] flag_q, mask_ext, pend, pick_onehot, clr_vec;
    logic [CODE_W-1:0] pick_code;
    logic              dma_rx_en, dma_tx_en;

    assign pend = flag_q & mask_ext;

    always_comb begin
        clr_vec = '0;
        if (NEW_REV != 0) begin
            if (stat_clr_we) clr_vec = stat_clr_data & SW_CLR_MASK;
        end else begin
            if (vec_rd) clr_vec = pick_onehot;
        end
    end

    irqv_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_pulse),
        .clr_vec (clr_vec),
        .flag_q  (flag_q)
    );

    irqv_prio u_prio (
        .pend        (pend),
        .pick_onehot (pick_onehot),
        .pick_code   (pick_code)
    );

    irqv_cfg #(.MASK_W(MASK_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (en_we),
        .en_data   (en_data),
        .dma_we    (dma_we),
        .dma_data  (dma_data),
        .mask_ext  (mask_ext),
        .dma_rx_en (dma_rx_en),
        .dma_tx_en (dma_tx_en)
    );

    always_comb begin
        stat_rd           = flag_q;
        stat_rd[BIT_BUSY] = busy_in;
        dma_rd            = '0;
        dma_rd[DMA_RX_BIT] = dma_rx_en;
        dma_rd[DMA_TX_BIT] = dma_tx_en;
    end

    assign en_rd    = mask_ext;
    assign vec_code = (NEW_REV != 0) ? '0 : pick_code;
    assign irq      = |pend;
    assign dreq_rx  = dma_rx_en & flag_q[BIT_RX_RDY];
    assign dreq_tx  = dma_tx_en & flag_q[BIT_TX_RDY];
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int NEW_REV = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] set_pulse,
    input logic        busy_in,
    input logic        dma_we,
    input logic [15:0] dma_data,
    input logic [4:0]  vec_code,
    input logic [15:0] stat_rd,
    input logic [15:0] en_rd,
    input logic [15:0] dma_rd,
    input logic        irq,
    input logic        dreq_rx,
    input logic        dreq_tx
);
    localparam logic [15:0] EN_LIMIT = (NEW_REV != 0) ? 16'h003F : 16'h001F;

    assert_irq_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(stat_rd & en_rd & 16'hEFFF)));

    assert_dreq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_rx |-> (dma_rd[15] && stat_rd[3])) and (dreq_tx |-> (dma_rd[7] && stat_rd[4])));

    assert_vec_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != 5'd0) |-> (((stat_rd & en_rd) >> (vec_code - 5'd1)) & 16'h1) == 16'h1);

    assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (NEW_REV != 0) |-> (!$fell(stat_rd[3]) && !$fell(stat_rd[4])));

    assert_en_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rd & ~EN_LIMIT) == 16'h0);

    assert_dma_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_we && dma_data[15]) |=> !en_rd[3]);

    assert_busy_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd[12] == busy_in);

    assert_set_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_pulse & 16'hEFFF)) |=> ((stat_rd & $past(set_pulse & 16'hEFFF)) == $past(set_pulse & 16'hEFFF)));
endmodule

bind irqv_top irqv_checker #(.NEW_REV(NEW_REV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (set_pulse),
    .busy_in   (busy_in),
    .dma_we    (dma_we),
    .dma_data  (dma_data),
    .vec_code  (vec_code),
    .stat_rd   (stat_rd),
    .en_rd     (en_rd),
    .dma_rd    (dma_rd),
    .irq       (irq),
    .dreq_rx   (dreq_rx),
    .dreq_tx   (dreq_tx)
);

// File: tb/tb_irqv_top.sv
`timescale 1ns/1ps
module tb_irqv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] set_pulse = '0, stat_clr_data = '0, en_data = '0, dma_data = '0;
    logic        busy_in = 1'b0, stat_clr_we = 1'b0, en_we = 1'b0, dma_we = 1'b0, vec_rd = 1'b0;
    logic [4:0]  n_code, o_code;
    logic [15:0] n_stat, n_en, n_dma, o_stat, o_en, o_dma;
    logic        n_irq, n_drx, n_dtx, o_irq, o_drx, o_dtx;
    int          checks = 0, fails = 0;

    always #4 clk = ~clk;

    irqv_top #(.NEW_REV(1)) dut (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .busy_in(busy_in),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data), .en_we(en_we), .en_data(en_data),
        .dma_we(dma_we), .dma_data(dma_data), .vec_rd(vec_rd), .vec_code(n_code), .stat_rd(n_stat),
        .en_rd(n_en), .dma_rd(n_dma), .irq(n_irq), .dreq_rx(n_drx), .dreq_tx(n_dtx));

    irqv_top #(.NEW_REV(0)) dut_old (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .busy_in(busy_in),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data), .en_we(en_we), .en_data(en_data),
        .dma_we(dma_we), .dma_data(dma_data), .vec_rd(vec_rd), .vec_code(o_code), .stat_rd(o_stat),
        .en_rd(o_en), .dma_rd(o_dma), .irq(o_irq), .dreq_rx(o_drx), .dreq_tx(o_dtx));

    typedef struct packed {
        logic [15:0] set;
        logic        clr_we;
        logic [15:0] clr;
        logic        en_we;
        logic [15:0] en;
        logic [15:0] exp_stat;
        logic        exp_irq;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{16'h0000, 1'b0, 16'h0000, 1'b1, 16'h003F, 16'h0000, 1'b0},
        '{16'h0002, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0002, 1'b1},
        '{16'h0000, 1'b1, 16'h0002, 1'b0, 16'h0000, 16'h0000, 1'b0},
        '{16'h0018, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0018, 1'b1},
        '{16'h0000, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 16'h0018, 1'b1},
        '{16'h1000, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0018, 1'b1},
        '{16'h0004, 1'b1, 16'h0004, 1'b0, 16'h0000, 16'h001C, 1'b1},
        '{16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0003, 16'h001C, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        set_pulse = '0; stat_clr_we = 0; stat_clr_data = '0; en_we = 0; en_data = '0;
        dma_we = 0; dma_data = '0; vec_rd = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 0;
        step();
        step();
        rst_n = 1;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R9 reset state
        chk("R9 stat", {16'h0, n_stat}, 32'h0);
        chk("R9 en", {16'h0, n_en}, 32'h0);
        chk("R9 outs", {29'h0, n_irq, n_drx, n_dtx}, 32'h0);

        // Table walk: R1 R4 R7 R8 R10 on the newer revision
        for (int i = 0; i < 8; i++) begin
            set_pulse = TBL[i].set; stat_clr_we = TBL[i].clr_we; stat_clr_data = TBL[i].clr;
            en_we = TBL[i].en_we; en_data = TBL[i].en;
            step();
            chk($sformatf("R10/R4/R8 stat row %0d", i), {16'h0, n_stat}, {16'h0, TBL[i].exp_stat});
            chk($sformatf("R1 irq row %0d", i), {31'h0, n_irq}, {31'h0, TBL[i].exp_irq});
        end

        // R7 busy is shown live, not stored
        busy_in = 1; #1;
        chk("R7 busy shown", {16'h0, n_stat}, 32'h101C);
        chk("R7 busy no irq", {31'h0, n_irq}, 32'h0);
        busy_in = 0; #1;
        chk("R7 busy gone", {16'h0, n_stat}, 32'h001C);

        // R6 / R2 DMA enables
        en_we = 1; en_data = 16'h003F; step();
        dma_we = 1; dma_data = 16'hFFFF; step();
        chk("R6 dma kept", {16'h0, n_dma}, 32'h8080);
        chk("R6 en forced", {16'h0, n_en}, 32'h0027);
        chk("R2 dreq both", {30'h0, n_drx, n_dtx}, 32'h3);
        dma_we = 1; dma_data = 16'h0080; step();
        chk("R2 rx gated", {30'h0, n_drx, n_dtx}, 32'h1);

        // Older revision: R5 R4 R3
        do_reset();
        en_we = 1; en_data = 16'h00FF; step();
        chk("R5 old width", {16'h0, o_en}, 32'h001F);
        chk("R5 new width", {16'h0, n_en}, 32'h003F);
        set_pulse = 16'h0026; step();
        stat_clr_we = 1; stat_clr_data = 16'h0026; step();
        chk("R4 old ignores write", {16'h0, o_stat}, 32'h0026);
        chk("R4 new clears", {16'h0, n_stat}, 32'h0000);
        chk("R3 old code", {27'h0, o_code}, 32'd2);
        chk("R3 new code zero", {27'h0, n_code}, 32'd0);
        set_pulse = 16'h0001; step();
        chk("R3 new vec no effect pre", {16'h0, n_stat}, 32'h0001);
        chk("R3 old lowest", {27'h0, o_code}, 32'd1);
        vec_rd = 1; step();
        chk("R3 old cleared bit0", {16'h0, o_stat}, 32'h0026);
        chk("R3 new vec no effect", {16'h0, n_stat}, 32'h0001);
        vec_rd = 1; step();
        chk("R3 old cleared bit1", {16'h0, o_stat}, 32'h0024);
        chk("R3 old next code", {27'h0, o_code}, 32'd3);
        vec_rd = 1; set_pulse = 16'h0004; step();
        chk("R8 set beats vec clear", {16'h0, o_stat}, 32'h0024);
        vec_rd = 1; step();
        chk("R3 masked bit left", {16'h0, o_stat}, 32'h0020);
        chk("R3 none pending", {27'h0, o_code}, 32'd0);
        vec_rd = 1; step();
        chk("R3 empty read", {16'h0, o_stat}, 32'h0020);
        chk("R1 old irq low", {31'h0, o_irq}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule